// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block moves left/right sample pairs between a processor core and an external converter over a three-wire serial link: bit clock, frame clock and one data line in each direction. In master mode it derives the bit clock and the frame clock from an incoming oversampling clock. The divide ratio follows from the selected oversampling factor (256, 384 or 512 times the frame rate) and the frame length (32 or 64 bit clocks). In slave mode the oversampling clock is ignored, and the port follows a bit clock and a frame clock driven by the external device.

Every external line is brought into the system clock domain through a two-stage synchroniser. Bit-clock edges are detected there. A channel slot starts at the falling bit-clock edge on which the frame clock level changes. At that edge the transmit word is loaded and its most significant bit is driven at once. Receive bits are taken on rising edges, and the finished word is handed to the core at the next slot start.

On the core side there is a small read/write port with a data address and a status address. The core can poll the status register or use the interrupt line. A one-word transmit holding register and a one-word receive holding register sit between the core and the shifters.

Top module: `aud_sport`

## Requirements
- R1: In master mode the bit clock period is (oversampling factor / frame length) master-clock periods. `ratio_sel` encodes the factor: 0 = 256, 1 = 384, 2 = 512.
- R2: In master mode a frame lasts 32 bit clocks (`frame64`=0) or 64 (`frame64`=1). The frame clock is low for the left half of the frame, high for the right half, and changes only on a falling bit clock.
- R3: In slave mode `bclk_o` and `lrclk_o` stay low, `mclk_i` has no effect, and the slot timing follows `bclk_i` and `lrclk_i`.
- R4: Transmit data leaves MSB first and changes only on falling bit-clock edges. A 64-bit frame sends all 32 bits of the word per slot. A 32-bit frame sends `wdata[15:0]` of the word.
- R5: Receive data is sampled on rising bit-clock edges, MSB first. At the next slot start it is placed in the receive register, zero-extended to 32 bits in a 32-bit frame.
- R6: At address 0 a write loads the transmit holding register and a read returns the received word and clears the receive-ready flag. At address 1 a read returns status: bit0 transmit-ready, bit1 receive-ready, bit2 underrun, bit3 overrun, bit4 channel of the held receive word (0 left, 1 right). `rdata` holds the result in the cycle after `rd_en`.
- R7: If no new transmit word is held when a slot starts, the previous word is sent again and the underrun bit is set.
- R8: If a received word replaces one the core has not read, the overrun bit is set.
- R9: Writing status with bit2 or bit3 set clears the matching sticky flag. Otherwise the flag stays set.
- R10: `irq` is high one cycle after transmit-ready or receive-ready is high, and low one cycle after both are low.
- R11: After reset, status reads 0x01, and `bclk_o`, `lrclk_o` and `sdo` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_master | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| ratio_sel | input | 2 | Master oversampling factor code |
| frame64 | input | 1 | 1 = 64-bit frame, 0 = 32-bit frame |
| mclk_i | input | 1 | Oversampling master clock (master mode) |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrclk_i | input | 1 | External frame clock (slave mode) |
| sdi | input | 1 | Serial receive data |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated frame clock |
| sdo | output | 1 | Serial transmit data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = data, 1 = status |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, registered |
| irq | output | 1 | Service request to the core |

## Verification
The assertions check on every cycle the timing relations that a single cycle can show. In slave mode the generated clocks stay quiet. In master mode the frame clock and transmit data move only as the bit clock falls. A data write always leaves a word pending, and the underrun and overrun flags never drop unless a status write clears them.

Only the bench scenarios can show the rest. These include the divide ratios and frame lengths measured across whole frames, and the bit order and word contents on the wire in both directions. They also cover the repeat of the previous word on underrun, overwriting of an unread word, and slave timing driven by an external clock pair.

// File: rtl/aud_sport_pkg.sv
package aud_sport_pkg;

  typedef enum logic [1:0] {
    OSR_256 = 2'd0,
    OSR_384 = 2'd1,
    OSR_512 = 2'd2
  } osr_e;

  localparam int ST_TXRDY = 0;
  localparam int ST_RXRDY = 1;
  localparam int ST_UNDER = 2;
  localparam int ST_OVER  = 3;
  localparam int ST_RXCH  = 4;

  // master-clock ticks per half bit-clock period
  function automatic logic [3:0] half_ticks(input logic [1:0] osr, input logic f64);
    logic [3:0] m;
    case (osr)
      OSR_384: m = 4'd3;
      OSR_512: m = 4'd4;
      default: m = 4'd2;
    endcase
    return f64 ? m : {m[2:0], 1'b0};
  endfunction

endpackage

// File: rtl/aud_sport_sync.sv
module aud_sport_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else     stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/aud_sport_clkgen.sv
module aud_sport_clkgen
  import aud_sport_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       master,
  input  logic [1:0] osr,
  input  logic       f64,
  input  logic       mclk_s,
  input  logic       bclk_s,
  input  logic       lrclk_s,
  output logic       fall_ev,
  output logic       rise_ev,
  output logic       lr_ev,
  output logic       bclk_o,
  output logic       lrclk_o
);
  localparam int BW = $clog2(2*WORD_W);
  localparam logic [BW-1:0] LAST_S = BW'(WORD_W - 1);
  localparam logic [BW-1:0] LAST_L = BW'(2*WORD_W - 1);
  localparam logic [BW-1:0] MID_S  = BW'(WORD_W / 2);
  localparam logic [BW-1:0] MID_L  = BW'(WORD_W);

  logic          mclk_d, bclk_d;
  logic [3:0]    hcnt, half;
  logic [BW-1:0] bitcnt, bit_nxt, last;
  logic          tick, tog, lr_nxt;

  assign half    = half_ticks(osr, f64);
  assign last    = f64 ? LAST_L : LAST_S;
  assign tick    = mclk_s & ~mclk_d;
  assign tog     = master & tick & (hcnt == half - 4'd1);
  assign bit_nxt = (bitcnt == last) ? '0 : bitcnt + 1'b1;
  assign lr_nxt  = bit_nxt >= (f64 ? MID_L : MID_S);

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_d <= 1'b0;
      bclk_d <= 1'b0;
    end else begin
      mclk_d <= mclk_s;
      bclk_d <= bclk_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !master) begin
      hcnt    <= '0;
      bclk_o  <= 1'b0;
      lrclk_o <= 1'b0;
      bitcnt  <= last;
    end else if (tick) begin
      if (tog) begin
        hcnt   <= '0;
        bclk_o <= ~bclk_o;
        if (bclk_o) begin
          bitcnt  <= bit_nxt;
          lrclk_o <= lr_nxt;
        end
      end else begin
        hcnt <= hcnt + 4'd1;
      end
    end
  end

  always_comb begin
    if (master) begin
      fall_ev = tog & bclk_o;
      rise_ev = tog & ~bclk_o;
      lr_ev   = lr_nxt;
    end else begin
      fall_ev = bclk_d & ~bclk_s;
      rise_ev = ~bclk_d & bclk_s;
      lr_ev   = lrclk_s;
    end
  end
endmodule

// File: rtl/aud_sport_shift.sv
module aud_sport_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              f64,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              lr_ev,
  input  logic              sdi_s,
  input  logic [WORD_W-1:0] tx_word,
  output logic              sdo,
  output logic              slot_start,
  output logic              rx_fire,
  output logic              slot_chan,
  output logic [WORD_W-1:0] rx_word
);
  localparam int SHORT_W = WORD_W / 2;

  logic              lr_cur, started;
  logic [WORD_W-1:0] tx_sh, tx_nxt, rx_sh;

  assign slot_start = fall_ev & (lr_ev != lr_cur);
  assign rx_fire    = slot_start & started;
  assign slot_chan  = lr_cur;
  assign rx_word    = f64 ? rx_sh : {{SHORT_W{1'b0}}, rx_sh[SHORT_W-1:0]};

  always_comb begin
    if (slot_start) tx_nxt = f64 ? tx_word : {tx_word[SHORT_W-1:0], {SHORT_W{1'b0}}};
    else            tx_nxt = {tx_sh[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_cur  <= 1'b1;
      started <= 1'b0;
      tx_sh   <= '0;
      sdo     <= 1'b0;
      rx_sh   <= '0;
    end else begin
      if (fall_ev) begin
        tx_sh <= tx_nxt;
        sdo   <= tx_nxt[WORD_W-1];
        if (slot_start) begin
          lr_cur  <= lr_ev;
          started <= 1'b1;
        end
      end
      if (rise_ev) rx_sh <= {rx_sh[WORD_W-2:0], sdi_s};
    end
  end
endmodule

// File: rtl/aud_sport.sv
module aud_sport
  import aud_sport_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_master,
  input  logic [1:0]        ratio_sel,
  input  logic              frame64,
  input  logic              mclk_i,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdi,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              sdo,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  logic [3:0] raw_s;
  logic       fall_ev, rise_ev, lr_ev;
  logic       slot_start, rx_fire, slot_chan;
  logic [WORD_W-1:0] rx_word, tx_word, status;
  logic [WORD_W-1:0] tx_hold, tx_last, rx_hold;
  logic       tx_full, rx_valid, rx_chan, flag_under, flag_over;
  logic       wr_data, wr_stat, rd_data;

  aud_sport_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({mclk_i, bclk_i, lrclk_i, sdi}),
    .q(raw_s)
  );

  aud_sport_clkgen #(.WORD_W(WORD_W)) u_clkgen (
    .clk(clk), .rst(rst), .master(mode_master), .osr(ratio_sel), .f64(frame64),
    .mclk_s(raw_s[3]), .bclk_s(raw_s[2]), .lrclk_s(raw_s[1]),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .lr_ev(lr_ev),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o)
  );

  aud_sport_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .f64(frame64),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .lr_ev(lr_ev), .sdi_s(raw_s[0]),
    .tx_word(tx_word), .sdo(sdo), .slot_start(slot_start), .rx_fire(rx_fire),
    .slot_chan(slot_chan), .rx_word(rx_word)
  );

  assign tx_word = tx_full ? tx_hold : tx_last;
  assign wr_data = wr_en & ~addr;
  assign wr_stat = wr_en & addr;
  assign rd_data = rd_en & ~addr;

  always_comb begin
    status           = '0;
    status[ST_TXRDY] = ~tx_full;
    status[ST_RXRDY] = rx_valid;
    status[ST_UNDER] = flag_under;
    status[ST_OVER]  = flag_over;
    status[ST_RXCH]  = rx_chan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold    <= '0;
      tx_last    <= '0;
      tx_full    <= 1'b0;
      rx_hold    <= '0;
      rx_valid   <= 1'b0;
      rx_chan    <= 1'b0;
      flag_under <= 1'b0;
      flag_over  <= 1'b0;
      rdata      <= '0;
      irq        <= 1'b0;
    end else begin
      if (wr_stat && wdata[ST_UNDER]) flag_under <= 1'b0;
      if (wr_stat && wdata[ST_OVER])  flag_over  <= 1'b0;
      if (slot_start) begin
        tx_last <= tx_word;
        tx_full <= 1'b0;
        if (!tx_full) flag_under <= 1'b1;
      end
      if (wr_data) begin
        tx_hold <= wdata;
        tx_full <= 1'b1;
      end
      if (rd_data) rx_valid <= 1'b0;
      if (rx_fire) begin
        rx_hold  <= rx_word;
        rx_chan  <= slot_chan;
        rx_valid <= 1'b1;
        if (rx_valid && !rd_data) flag_over <= 1'b1;
      end
      if (rd_en) rdata <= addr ? status : rx_hold;
      else       rdata <= '0;
      irq <= ~tx_full | rx_valid;
    end
  end
endmodule

// File: rtl/aud_sport_chk.sv
module aud_sport_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_master,
  input logic              bclk_o,
  input logic              lrclk_o,
  input logic              sdo,
  input logic              wr_en,
  input logic              addr,
  input logic [WORD_W-1:0] wdata,
  input logic              tx_full,
  input logic              flag_under,
  input logic              flag_over
);
  p_slave_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !mode_master |-> (!bclk_o && !lrclk_o));

  p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_master && lrclk_o != $past(lrclk_o)) |-> ($past(bclk_o) && !bclk_o));

  p_sdo_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_master && sdo != $past(sdo)) |-> ($past(bclk_o) && !bclk_o));

  p_tx_pending_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr) |=> tx_full);

  p_under_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_under) && !($past(wr_en) && $past(addr) && $past(wdata[2]))) |-> flag_under);

  p_over_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_over) && !($past(wr_en) && $past(addr) && $past(wdata[3]))) |-> flag_over);
endmodule

bind aud_sport aud_sport_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .mode_master(mode_master), .bclk_o(bclk_o),
  .lrclk_o(lrclk_o), .sdo(sdo), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tx_full(tx_full), .flag_under(flag_under), .flag_over(flag_over)
);

// File: tb/aud_sport_bench.sv
module aud_sport_bench;
  logic clk = 1'b0, mclk_i = 1'b0;
  always #2 clk = ~clk;
  always #8 mclk_i = ~mclk_i;

  logic rst = 1'b1, mode_master = 1'b1, frame64 = 1'b0;
  logic [1:0] ratio_sel = 2'd0;
  logic bclk_i, lrclk_i, sdi, bclk_o, lrclk_o, sdo, irq;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0, rdata;

  aud_sport u_aud_sport (
    .clk(clk), .rst(rst), .mode_master(mode_master), .ratio_sel(ratio_sel),
    .frame64(frame64), .mclk_i(mclk_i), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .sdi(sdi), .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sdo(sdo), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int n_tests = 0, n_fail = 0, dev_checks = 0, dev_bad = 0;
  logic dev_on = 1'b0, gen_on = 1'b0;
  logic [31:0] word_l, word_r, exp_l, exp_r;
  string cfg_tag = "R4";

  wire line_b  = mode_master ? bclk_o  : bclk_i;
  wire line_lr = mode_master ? lrclk_o : lrclk_i;

  // external device model: drives sdi, captures sdo, measures timing
  int dev_slots, idx, rise_cnt, cyc, last_rise, m_per, m_frame, m_left, o_moves, sw;
  logic pb, dlr, have_slot, seen_left;
  logic [31:0] cap, cur, msk, got, want;
  always @(negedge clk) begin
    sw  = frame64 ? 32 : 16;
    msk = frame64 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    if (!dev_on) begin
      pb = line_b; dlr = 1'b1; idx = 0; cap = '0; cur = '0; have_slot = 1'b0;
      seen_left = 1'b0; rise_cnt = 0; dev_slots = 0; cyc = 0; last_rise = -1;
      m_per = 0; m_frame = 0; m_left = 0; o_moves = 0; sdi = 1'b0;
    end else begin
      cyc++;
      if (!mode_master && (bclk_o || lrclk_o)) o_moves++;
      if (line_b && !pb) begin
        cap = {cap[30:0], sdo};
        rise_cnt++;
        if (last_rise >= 0) m_per = cyc - last_rise;
        last_rise = cyc;
      end
      if (!line_b && pb) begin
        if (line_lr != dlr) begin
          if (have_slot) begin
            got  = cap & msk;
            want = (dlr ? exp_r : exp_l) & msk;
            dev_checks++;
            if (got !== want) begin
              dev_bad++;
              $display("FAIL %s slot ch%0d: got %h expected %h", cfg_tag, dlr, got, want);
            end
            dev_slots++;
          end
          if (!line_lr) begin
            if (seen_left) m_frame = rise_cnt;
            seen_left = 1'b1;
            rise_cnt = 0;
          end else begin
            m_left = rise_cnt;
          end
          have_slot = 1'b1; dlr = line_lr; idx = 0;
          cur = line_lr ? word_r : word_l;
          sdi = cur[sw-1];
        end else begin
          idx++;
          sdi = (idx < sw) ? cur[sw-1-idx] : 1'b0;
        end
      end
      pb = line_b;
    end
  end

  // external clock source for slave mode: half bit period of 8 cycles
  int gcnt, gpos;
  initial begin
    forever begin
      @(negedge clk);
      if (!gen_on) begin
        gcnt = 0; bclk_i = 1'b0; lrclk_i = 1'b1; gpos = frame64 ? 63 : 31;
      end else begin
        gcnt++;
        if (gcnt == 8) begin
          gcnt = 0;
          if (bclk_i) begin
            bclk_i = 1'b0;
            gpos = (gpos == (frame64 ? 63 : 31)) ? 0 : gpos + 1;
            lrclk_i = (gpos >= (frame64 ? 32 : 16));
          end else begin
            bclk_i = 1'b1;
          end
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic do_reset(input logic m, input logic [1:0] r, input logic f);
    dev_on = 1'b0; gen_on = 1'b0;
    @(negedge clk); rst = 1'b1; mode_master = m; ratio_sel = r; frame64 = f;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_core(input int target, input logic [31:0] tl, input logic [31:0] tr,
                          input logic [31:0] rl, input logic [31:0] rr, input logic f,
                          output int rx_seen);
    logic [31:0] st, d, m, e;
    logic sel;
    sel = 1'b0; rx_seen = 0;
    m = f ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    while (dev_slots < target) begin
      bus_read(1'b1, st);
      if (st[0]) begin
        bus_write(1'b0, sel ? tr : tl);
        sel = ~sel;
      end
      if (st[1]) begin
        bus_read(1'b0, d);
        e = (st[4] ? rr : rl) & m;
        chk(d == e, "R5", "received word", d, e);
        rx_seen++;
      end
    end
  endtask

  // {master, ratio, frame64, txL, txR, rxL, rxR}
  localparam logic [131:0] VEC [6] = '{
    {1'b1, 2'd0, 1'b0, 32'hDEAD_A5C3, 32'h0000_3C5A, 32'h0000_F00D, 32'h0000_1234},
    {1'b1, 2'd1, 1'b1, 32'h8123_4567, 32'h0FED_CBA9, 32'hCAFE_F00D, 32'h1357_9BDF},
    {1'b1, 2'd2, 1'b0, 32'h0000_8001, 32'h0000_7FFE, 32'h0000_C001, 32'h0000_0003},
    {1'b1, 2'd1, 1'b0, 32'h0000_5A5A, 32'h0000_FF00, 32'h0000_0F0F, 32'h0000_8888},
    {1'b0, 2'd0, 1'b0, 32'h0000_1357, 32'h0000_ECA8, 32'h0000_ABCD, 32'h0000_4321},
    {1'b0, 2'd2, 1'b1, 32'hF0E1_D2C3, 32'h0123_4567, 32'h89AB_CDEF, 32'h7654_3210}
  };

  logic done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL R6 watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests + dev_checks + 1, n_fail + dev_bad + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, d;
    int rx_seen, bad, half, mult;

    // vector table: several modes, ratios and frame lengths
    for (int v = 0; v < 6; v++) begin
      logic [131:0] t;
      t = VEC[v];
      word_l = t[63:32]; word_r = t[31:0]; exp_l = t[127:96]; exp_r = t[95:64];
      cfg_tag = "R4";
      do_reset(t[131], t[130:129], t[128]);
      dev_on = 1'b1; gen_on = ~t[131];
      run_core(9, t[127:96], t[95:64], t[63:32], t[31:0], t[128], rx_seen);
      chk(rx_seen > 2, "R5", "received words seen", 32'(rx_seen), 32'd3);
      chk(m_frame == (t[128] ? 64 : 32), "R2", "bit clocks per frame", 32'(m_frame), t[128] ? 32'd64 : 32'd32);
      chk(m_left == (t[128] ? 32 : 16), "R2", "bit clocks in left half", 32'(m_left), t[128] ? 32'd32 : 32'd16);
      if (t[131]) begin
        mult = (t[130:129] == 2'd1) ? 3 : (t[130:129] == 2'd2) ? 4 : 2;
        half = t[128] ? mult : 2 * mult;
        chk(m_per == 8 * half, "R1", "bit clock period", 32'(m_per), 32'(8 * half));
      end else begin
        chk(o_moves == 0, "R3", "generated clocks in slave", 32'(o_moves), 32'd0);
        chk(m_per == 16, "R3", "follows external bit clock", 32'(m_per), 32'd16);
      end
      dev_on = 1'b0; gen_on = 1'b0;
    end

    // reset state (slave, no external clocks)
    do_reset(1'b0, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    chk(!bclk_o && !lrclk_o && !sdo, "R11", "serial outputs after reset",
        {29'd0, bclk_o, lrclk_o, sdo}, 32'd0);
    bus_read(1'b1, st);
    chk(st == 32'h1, "R11", "status after reset", st, 32'h1);
    chk(irq == 1'b1, "R10", "irq with transmit ready", {31'd0, irq}, 32'd1);

    // write clears transmit-ready and irq; mclk has no effect in slave mode
    bus_write(1'b0, 32'h0000_AAAA);
    @(negedge clk);
    chk(irq == 1'b0, "R10", "irq with nothing pending", {31'd0, irq}, 32'd0);
    bus_read(1'b1, st);
    chk(st == 32'h0, "R6", "status after data write", st, 32'h0);
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bclk_o || lrclk_o || sdo) bad++;
    end
    chk(bad == 0, "R3", "outputs quiet with mclk toggling", 32'(bad), 32'd0);

    // underrun, overrun and flag clearing (master, 256x, 32-bit frame)
    do_reset(1'b1, 2'd0, 1'b0);
    word_l = 32'h0000_9C31; word_r = 32'h0000_6A05;
    exp_l = 32'h0000_BEEF; exp_r = 32'h0000_BEEF;
    cfg_tag = "R7";
    bus_write(1'b0, 32'h1234_BEEF);
    dev_on = 1'b1;
    while (dev_slots < 4) @(negedge clk);
    bus_read(1'b1, st);
    chk(st[2] == 1'b1, "R7", "underrun flag", {31'd0, st[2]}, 32'd1);
    chk(st[3] == 1'b1, "R8", "overrun flag", {31'd0, st[3]}, 32'd1);
    bus_read(1'b0, d);
    chk(d == (st[4] ? 32'h0000_6A05 : 32'h0000_9C31), "R8", "latest word kept",
        d, st[4] ? 32'h0000_6A05 : 32'h0000_9C31);
    st[0] = lrclk_o;
    while (lrclk_o == st[0]) @(negedge clk);
    bus_write(1'b1, 32'h0000_000C);
    bus_read(1'b1, st);
    chk(st[3:2] == 2'b00, "R9", "flags cleared", {30'd0, st[3:2]}, 32'd0);
    dev_on = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests + dev_checks, n_fail + dev_bad);
    $finish;
  end
endmodule